// File: doc/BRIEF.md
# Keyboard Capture Register Pair

This peripheral sits between a parallel keyboard and a processor's memory-mapped I/O space. The keyboard presents an 8-bit character code together with a keypress strobe. The code lines are valid only while the strobe is high. The block synchronises the strobe to the system clock and detects its leading edge. On that edge it captures the code and raises a ready flag.

Software polls a status byte, or waits for the interrupt request, and then reads the code byte. That read clears the ready flag. A key that arrives while the previous character is still unread leaves a sticky overrun indication. The indication stays until the code byte is read.

The bus side carries three strobes: read code byte, read status byte and write status byte. Address decoding happens upstream. A read returns its byte combinationally on the shared read bus in the cycle its strobe is high. Any side effect of the read takes hold at the clock edge that ends that cycle.

Top module: `keyin_regs`

## Requirements
- R1: Synchronous reset clears the ready flag, the overrun flag, the interrupt-enable bit and the captured code, so both bytes read 0x00 and `irq` is low.
- R2: A rising edge on `keyStrobe` is detected at the third rising clock edge after the strobe goes high. At that same clock edge, the block captures `keyCode` and sets the ready flag.
- R3: While `rdCode` is high, `rdBus` shows the most recently captured code. When neither read strobe is high, `rdBus` is 0x00. No bus write changes the captured code.
- R4: A code-byte read clears both the ready flag and the overrun flag at the end of the read cycle.
- R5: At each detected keypress, the overrun flag takes the value the ready flag held just before that edge. A key arriving while ready is 1 therefore reads back as overrun 1, and a key arriving while ready is 0 reads back as overrun 0.
- R6: A strobe held high produces exactly one keypress event. Later code changes during the same hold are not captured, and ready stays clear after a read until the strobe falls and rises again.
- R7: The status byte reads as {enable, overrun, 5'b00000, ready}: bit 7 is interrupt enable, bit 6 is overrun, bit 0 is ready, and bits 1 to 5 are 0. A status write loads the enable bit from `wrData[7]` and ignores every other written bit.
- R8: `irq` is high exactly while the enable bit and the ready flag are both 1.
- R9: When a code-byte read and a detected keypress fall in the same cycle, the keypress wins. Ready ends at 1, overrun takes the pre-edge ready value, and the new code is captured.
- R10: A status-byte read has no side effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| keyStrobe | input | 1 | Keypress strobe from the keyboard, asynchronous |
| keyCode | input | 8 | Key code, valid while keyStrobe is high |
| rdCode | input | 1 | Bus read of the code byte (offset 0) |
| rdStat | input | 1 | Bus read of the status byte (offset 4) |
| wrStat | input | 1 | Bus write of the status byte (offset 4) |
| wrData | input | 8 | Bus write data |
| rdBus | output | 8 | Bus read data, 0 when no read strobe is high |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a code-byte read that lands in the one cycle in which the synchronised keypress edge is being acted on. Reaching it requires counting the synchroniser latency exactly. The bench raises the strobe and waits two clock edges. It then drives the read strobe for the single cycle that ends at the third edge. It does this once with ready already set and once with ready clear, which shows that the keypress wins and that overrun follows the pre-edge ready value. A second awkward case is a long strobe hold with a code change in the middle. It shows that only the leading edge counts and that a read during the hold leaves ready clear.

// File: rtl/keyin_pkg.sv
package keyin_pkg;

  // Strobes from the control half to the datapath half, valid for one cycle.
  typedef struct packed {
    logic keyEvent;   // synchronised leading edge of the keypress strobe
    logic flagClear;  // code-byte read with no competing keypress
    logic ieLoad;     // status-byte write
  } keyin_ctl_t;

endpackage

// File: rtl/keyin_ctrl.sv
module keyin_ctrl
  import keyin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       keyStrobe,
  input  logic       rdCode,
  input  logic       wrStat,
  output keyin_ctl_t ctl
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic         lastQ;
  logic         keyEdge;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= keyStrobe;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[TOP-1:0], keyStrobe};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lastQ <= 1'b0;
    else     lastQ <= syncQ[TOP];
  end

  assign keyEdge = syncQ[TOP] & ~lastQ;

  always_comb begin
    ctl.keyEvent  = keyEdge;
    // A keypress in the same cycle takes priority over the read-side clear.
    ctl.flagClear = rdCode & ~keyEdge;
    ctl.ieLoad    = wrStat;
  end

endmodule

// File: rtl/keyin_dp.sv
module keyin_dp
  import keyin_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int RDY_BIT = 0,
  parameter int ERR_BIT = 6,
  parameter int IE_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  keyin_ctl_t        ctl,
  input  logic [CODE_W-1:0] keyCode,
  input  logic [CODE_W-1:0] wrData,
  input  logic              rdCode,
  input  logic              rdStat,
  output logic [CODE_W-1:0] rdBus,
  output logic              irq,
  output logic              readyQ,
  output logic              errQ,
  output logic              ieQ
);

  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] statByte;
  logic              unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk) begin
    if (rst) begin
      codeQ  <= '0;
      readyQ <= 1'b0;
      errQ   <= 1'b0;
    end else if (ctl.keyEvent) begin
      codeQ  <= keyCode;
      readyQ <= 1'b1;
      errQ   <= readyQ;
    end else if (ctl.flagClear) begin
      readyQ <= 1'b0;
      errQ   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             ieQ <= 1'b0;
    else if (ctl.ieLoad) ieQ <= wrData[IE_BIT];
  end

  always_comb begin
    statByte          = '0;
    statByte[RDY_BIT] = readyQ;
    statByte[ERR_BIT] = errQ;
    statByte[IE_BIT]  = ieQ;
  end

  always_comb begin
    if (rdCode)      rdBus = codeQ;
    else if (rdStat) rdBus = statByte;
    else             rdBus = '0;
  end

  assign irq = ieQ & readyQ;

endmodule

// File: rtl/keyin_regs.sv
module keyin_regs
  import keyin_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              keyStrobe,
  input  logic [CODE_W-1:0] keyCode,
  input  logic              rdCode,
  input  logic              rdStat,
  input  logic              wrStat,
  input  logic [CODE_W-1:0] wrData,
  output logic [CODE_W-1:0] rdBus,
  output logic              irq
);

  keyin_ctl_t ctlBus;
  logic       keyEdge;
  logic       readyQ;
  logic       errQ;
  logic       ieQ;

  keyin_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .keyStrobe(keyStrobe),
    .rdCode   (rdCode),
    .wrStat   (wrStat),
    .ctl      (ctlBus)
  );

  keyin_dp #(.CODE_W(CODE_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctlBus),
    .keyCode(keyCode),
    .wrData (wrData),
    .rdCode (rdCode),
    .rdStat (rdStat),
    .rdBus  (rdBus),
    .irq    (irq),
    .readyQ (readyQ),
    .errQ   (errQ),
    .ieQ    (ieQ)
  );

  assign keyEdge = ctlBus.keyEvent;

endmodule

// File: rtl/keyin_regs_chk.sv
module keyin_regs_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rdCode,
  input logic              rdStat,
  input logic              wrStat,
  input logic              irq,
  input logic              keyEdge,
  input logic              readyQ,
  input logic              errQ,
  input logic              ieQ,
  input logic [CODE_W-1:0] rdBus
);

  // R2
  key_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
    keyEdge |=> readyQ);

  // R4
  read_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (rdCode && !keyEdge) |=> (!readyQ && !errQ));

  // R5
  overrun_sample_chk: assert property (@(posedge clk) disable iff (rst)
    keyEdge |=> (errQ == $past(readyQ)));

  // R6
  single_event_chk: assert property (@(posedge clk) disable iff (rst)
    keyEdge |=> !keyEdge);

  // R7
  ie_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrStat |=> $stable(ieQ));

  // R7
  stat_gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdStat && !rdCode) |-> (rdBus[5:1] == 5'b0));

  // R8
  irq_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ieQ && readyQ));

  // R10
  stat_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rdStat && !rdCode && !keyEdge) |=> ($stable(readyQ) && $stable(errQ)));

endmodule

bind keyin_regs keyin_regs_chk #(.CODE_W(CODE_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rdCode (rdCode),
  .rdStat (rdStat),
  .wrStat (wrStat),
  .irq    (irq),
  .keyEdge(keyEdge),
  .readyQ (readyQ),
  .errQ   (errQ),
  .ieQ    (ieQ),
  .rdBus  (rdBus)
);

// File: tb/keyin_regs_test.sv
module keyin_regs_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       keyStrobe = 1'b0;
  logic [7:0] keyCode = 8'h00;
  logic       rdCode = 1'b0;
  logic       rdStat = 1'b0;
  logic       wrStat = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdBus;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyin_regs uut (
    .clk(clk), .rst(rst), .keyStrobe(keyStrobe), .keyCode(keyCode),
    .rdCode(rdCode), .rdStat(rdStat), .wrStat(wrStat), .wrData(wrData),
    .rdBus(rdBus), .irq(irq)
  );

  // Each entry is {code, readAfter}.
  localparam logic [8:0] PRESS_TBL [8] = '{
    {8'h41, 1'b1}, {8'h62, 1'b0}, {8'h33, 1'b0}, {8'h7E, 1'b1},
    {8'h00, 1'b1}, {8'hFF, 1'b0}, {8'h0D, 1'b1}, {8'h5A, 1'b1}
  };

  logic mReady = 1'b0;
  logic mErr   = 1'b0;
  logic mIe    = 1'b0;
  logic [7:0] mCode = 8'h00;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] statExp();
    return {mIe, mErr, 5'b00000, mReady};
  endfunction

  task automatic readByte(input bit codeSel, output logic [7:0] val);
    @(negedge clk);
    rdCode = codeSel;
    rdStat = ~codeSel;
    #1 val = rdBus;
    @(negedge clk);
    rdCode = 1'b0;
    rdStat = 1'b0;
  endtask

  task automatic writeStat(input logic [7:0] d);
    @(negedge clk);
    wrStat = 1'b1;
    wrData = d;
    @(negedge clk);
    wrStat = 1'b0;
    wrData = 8'h00;
  endtask

  task automatic pressKey(input logic [7:0] code);
    @(negedge clk);
    keyStrobe = 1'b1;
    keyCode = code;
    repeat (5) @(negedge clk);
    keyStrobe = 1'b0;
    keyCode = 8'hA5;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    readByte(1'b0, v); check("R1 status after reset", v, 8'h00);
    readByte(1'b1, v); check("R1 code after reset", v, 8'h00);
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    check("R3 idle bus", rdBus, 8'h00);

    // Table-driven keystrokes: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      logic [7:0] code;
      logic readAfter;
      code = PRESS_TBL[i][8:1];
      readAfter = PRESS_TBL[i][0];
      pressKey(code);
      mErr = mReady;
      mReady = 1'b1;
      mCode = code;
      readByte(1'b0, v); check("R5 status after key", v, statExp());
      readByte(1'b0, v); check("R10 status read leaves flags", v, statExp());
      if (readAfter) begin
        readByte(1'b1, v); check("R2 captured code", v, mCode);
        mReady = 1'b0;
        mErr = 1'b0;
        readByte(1'b0, v); check("R4 flags cleared by read", v, statExp());
      end
    end

    // Clean state for the directed tests
    readByte(1'b1, v);
    mReady = 1'b0; mErr = 1'b0;

    // R2 latency: ready not visible before the third edge, visible right after
    @(negedge clk);
    keyStrobe = 1'b1; keyCode = 8'h21;
    @(negedge clk); @(negedge clk);
    rdStat = 1'b1; #1 check("R2 ready not yet set", rdBus, 8'h00);
    @(negedge clk);
    #1 check("R2 ready set at third edge", rdBus, 8'h01);
    rdStat = 1'b0;
    repeat (2) @(negedge clk);
    keyStrobe = 1'b0;
    repeat (3) @(negedge clk);
    mReady = 1'b1; mCode = 8'h21;
    readByte(1'b1, v); check("R2 code after latency test", v, 8'h21);
    mReady = 1'b0;

    // R7 enable write: only bit 7 counts
    writeStat(8'h7F);
    readByte(1'b0, v); check("R7 write without bit 7", v, 8'h00);
    writeStat(8'h80);
    mIe = 1'b1;
    readByte(1'b0, v); check("R7 enable bit readback", v, 8'h80);
    check("R8 irq low without ready", {7'b0, irq}, 8'h00);
    readByte(1'b1, v); check("R3 write leaves code", v, 8'h21);

    // R8 irq follows ready when enabled
    pressKey(8'h4B);
    mReady = 1'b1;
    check("R8 irq with enable and ready", {7'b0, irq}, 8'h01);
    readByte(1'b1, v); check("R3 code readback", v, 8'h4B);
    mReady = 1'b0;
    check("R8 irq drops after read", {7'b0, irq}, 8'h00);
    writeStat(8'h00); mIe = 1'b0;
    pressKey(8'h4C);
    check("R8 irq low when disabled", {7'b0, irq}, 8'h00);
    readByte(1'b1, v);

    // R6 long hold with code change and a read during the hold
    @(negedge clk);
    keyStrobe = 1'b1; keyCode = 8'h11;
    repeat (5) @(negedge clk);
    keyCode = 8'h22;
    readByte(1'b1, v); check("R6 first code only", v, 8'h11);
    repeat (6) @(negedge clk);
    readByte(1'b0, v); check("R6 no second event during hold", v, 8'h00);
    keyStrobe = 1'b0;
    repeat (3) @(negedge clk);
    readByte(1'b1, v); check("R6 code kept after release", v, 8'h11);

    // R9 collision with ready already set: keypress wins, overrun set
    pressKey(8'h30);
    @(negedge clk);
    keyStrobe = 1'b1; keyCode = 8'h31;
    @(negedge clk); @(negedge clk);
    rdCode = 1'b1;
    @(negedge clk);
    rdCode = 1'b0;
    readByte(1'b0, v); check("R9 collision with ready set", v, 8'h41);
    repeat (2) @(negedge clk);
    keyStrobe = 1'b0;
    repeat (3) @(negedge clk);
    readByte(1'b1, v); check("R9 new code captured", v, 8'h31);
    readByte(1'b0, v); check("R4 cleared after collision", v, 8'h00);

    // R9 collision with ready clear: no overrun
    @(negedge clk);
    keyStrobe = 1'b1; keyCode = 8'h32;
    @(negedge clk); @(negedge clk);
    rdCode = 1'b1;
    @(negedge clk);
    rdCode = 1'b0;
    readByte(1'b0, v); check("R9 collision with ready clear", v, 8'h01);
    repeat (2) @(negedge clk);
    keyStrobe = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset mid-operation
    writeStat(8'h80);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    readByte(1'b0, v); check("R1 status after second reset", v, 8'h00);
    readByte(1'b1, v); check("R1 code after second reset", v, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule